// File: doc/BRIEF.md
# Three-Axis Sample FIFO Controller

This block holds up to 32 angular-rate samples, each made of three signed 14-bit axis values, between a sampling engine that produces them and a host that drains them. A single 8-bit setup byte chooses the operating mode and the watermark level. The mode decides what happens when a sample arrives and the buffer is full. In the overwrite mode the oldest sample is lost. In the halting mode the new sample is dropped. In the trigger-armed mode the block overwrites until a trigger arrives and then halts.

The host reads the oldest sample one axis value at a time through a pop strobe. The presented value moves from X to Y to Z, and the sample leaves the buffer once its Z value has been popped. The block reports its fill count, a watermark flag and an overflow flag. It also reports their OR as an event flag, and raises a source flag toward an interrupt controller that a status-read strobe clears. Entering the active operating state pulses a clear input, which empties the buffer and resets every flag.

Top module: `fifo3ax_ctrl`

## Requirements
- R1: A one-cycle pulse on `act_entry` (or reset) leaves `fill_cnt` at 0, `ovf_flag`, `event_flag` and `src_flag` at 0, and `rd_axis` at 0 (X) after the next clock edge. A sample offered in that cycle is not stored.
- R2: `fifo_setup` bits 7:6 select the mode: 00 disabled, 01 overwrite, 10 halting, 11 trigger-armed. Bits 5:0 are the watermark. In the disabled mode arriving samples are ignored and `fill_cnt` does not change.
- R3: Samples leave in arrival order. `rd_data` shows the head sample's X, Y, then Z value as `rd_axis` reads 0, 1, 2, and each pop advances the axis. The pop made with `rd_axis` = 2 removes the sample: `fill_cnt` drops by one and `rd_axis` returns to 0. A pop while empty changes nothing, and `fill_cnt` never exceeds 32.
- R4: In overwrite mode a sample arriving at a count of 32 replaces the oldest one. The count stays 32, the next-oldest sample becomes the head, and `rd_axis` returns to 0.
- R5: In halting mode a sample arriving at a count of 32 is dropped, and the count and head stay unchanged.
- R6: In trigger-armed mode the block acts as overwrite mode until `trig_in` is seen, and from then on as halting mode. The armed state is cleared by `act_entry` or by any other mode value.
- R7: `ovf_flag` rises after an enabled sample arrives at a count of 32 in a cycle with no sample-removing pop. It stays set until the count falls below 32.
- R8: `wmrk_flag` is 1 exactly when the watermark field is nonzero and `fill_cnt` is greater than or equal to it.
- R9: `event_flag` is the OR of `wmrk_flag` and `ovf_flag`.
- R10: `src_flag` is set at the clock edge after `event_flag` rises from 0 to 1. It is cleared by `stat_rd`, unless a new rise of `event_flag` occurs in that same cycle.
- R11: When a sample arrives in the same cycle as a sample-removing pop, both take effect. The count is unchanged and, even at a count of 32, no overflow is recorded and nothing is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_entry | input | 1 | Clear pulse on entry to the active state |
| fifo_setup | input | 8 | Mode in bits 7:6, watermark in bits 5:0 |
| trig_in | input | 1 | Trigger for trigger-armed mode |
| smp_valid | input | 1 | New sample present |
| smp_x | input | 14 | X axis value of the new sample |
| smp_y | input | 14 | Y axis value of the new sample |
| smp_z | input | 14 | Z axis value of the new sample |
| pop_strb | input | 1 | Consume the presented axis value |
| stat_rd | input | 1 | Status read, clears the source flag |
| rd_data | output | 14 | Presented axis value of the head sample |
| rd_axis | output | 2 | Presented axis: 0 X, 1 Y, 2 Z |
| fill_cnt | output | 6 | Number of stored samples, 0 to 32 |
| wmrk_flag | output | 1 | Count at or above the watermark |
| ovf_flag | output | 1 | Sample arrived while full |
| event_flag | output | 1 | Watermark or overflow |
| src_flag | output | 1 | Latched event toward the interrupt controller |

## Verification
A wrong pointer or axis state shows up on `rd_data` at the very next pop. It appears as a value from the wrong sample or the wrong axis, which the bench can tell apart because it encodes the sample number in all three axis values. A count that is off by one shows on `fill_cnt` and `wmrk_flag` in the cycle after the offending edge. A wrong full decision shows on the head value after one more arrival: the head has moved in halting mode, or has not moved in overwrite mode. A stale overflow or source state shows after the pop that should have cleared it, or after the status read that should have cleared it.

// File: rtl/fifo3ax_ctrl.sv
`timescale 1ns/1ps
module fifo3ax_ctrl #(
  parameter int DEPTH = 32,
  parameter int DW    = 14,
  parameter int WMW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_entry,
  input  logic [WMW+1:0]    fifo_setup,
  input  logic              trig_in,
  input  logic              smp_valid,
  input  logic [DW-1:0]     smp_x,
  input  logic [DW-1:0]     smp_y,
  input  logic [DW-1:0]     smp_z,
  input  logic              pop_strb,
  input  logic              stat_rd,
  output logic [DW-1:0]     rd_data,
  output logic [1:0]        rd_axis,
  output logic [$clog2(DEPTH+1)-1:0] fill_cnt,
  output logic              wmrk_flag,
  output logic              ovf_flag,
  output logic              event_flag,
  output logic              src_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int SW = 3*DW;
  localparam int XW = (CW > WMW) ? CW : WMW;

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          trig_hold, evt_q;

  logic [1:0]     mode;
  logic [WMW-1:0] wm;
  assign mode = fifo_setup[WMW+1:WMW];
  assign wm   = fifo_setup[WMW-1:0];

  logic full, empty, frozen, arrive, pop_ok, pop_done, wr_take, ovr, ovf_hit, rd_adv;
  assign full     = (fill_cnt == CW'(DEPTH));
  assign empty    = (fill_cnt == '0);
  assign frozen   = (mode == 2'b10) || ((mode == 2'b11) && trig_hold);
  assign arrive   = smp_valid && (mode != 2'b00);
  assign pop_ok   = pop_strb && !empty;
  assign pop_done = pop_ok && (rd_axis == 2'd2);
  assign wr_take  = arrive && (!full || pop_done || !frozen);
  assign ovr      = arrive && full && !pop_done && !frozen;
  assign ovf_hit  = arrive && full && !pop_done;
  assign rd_adv   = pop_done || ovr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      fill_cnt  <= '0;
      rd_axis   <= '0;
      ovf_flag  <= 1'b0;
      trig_hold <= 1'b0;
      evt_q     <= 1'b0;
      src_flag  <= 1'b0;
    end else if (act_entry) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      fill_cnt  <= '0;
      rd_axis   <= '0;
      ovf_flag  <= 1'b0;
      trig_hold <= 1'b0;
      evt_q     <= 1'b0;
      src_flag  <= 1'b0;
    end else begin
      if (wr_take) wr_ptr <= bump(wr_ptr);
      if (rd_adv)  rd_ptr <= bump(rd_ptr);
      if (wr_take && !rd_adv)      fill_cnt <= fill_cnt + 1'b1;
      else if (rd_adv && !wr_take) fill_cnt <= fill_cnt - 1'b1;
      if (ovr || pop_done) rd_axis <= '0;
      else if (pop_ok)     rd_axis <= rd_axis + 1'b1;
      if (ovf_hit)                  ovf_flag <= 1'b1;
      else if (pop_done && !wr_take) ovf_flag <= 1'b0;
      if (mode != 2'b11) trig_hold <= 1'b0;
      else if (trig_in)  trig_hold <= 1'b1;
      evt_q    <= event_flag;
      src_flag <= (src_flag && !stat_rd) || (event_flag && !evt_q);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take && !act_entry) mem[wr_ptr] <= {smp_z, smp_y, smp_x};
  end

  logic [SW-1:0] head;
  assign head = mem[rd_ptr];

  always_comb begin
    case (rd_axis)
      2'd1:    rd_data = head[2*DW-1:DW];
      2'd2:    rd_data = head[3*DW-1:2*DW];
      default: rd_data = head[DW-1:0];
    endcase
  end

  assign wmrk_flag  = (wm != '0) && (XW'(fill_cnt) >= XW'(wm));
  assign event_flag = wmrk_flag || ovf_flag;
endmodule

module fifo3ax_ctrl_chk #(
  parameter int DEPTH = 32,
  parameter int WMW   = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       act_entry,
  input logic [WMW+1:0]             fifo_setup,
  input logic                       pop_strb,
  input logic                       stat_rd,
  input logic [1:0]                 rd_axis,
  input logic [$clog2(DEPTH+1)-1:0] fill_cnt,
  input logic                       ovf_flag,
  input logic                       event_flag,
  input logic                       src_flag
);
  localparam int CW = $clog2(DEPTH+1);

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    act_entry |=> (fill_cnt == '0 && !ovf_flag && !src_flag && rd_axis == 2'd0));

  assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_setup[WMW+1:WMW] == 2'b00 && !pop_strb && !act_entry) |=> $stable(fill_cnt));

  assert_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt <= CW'(DEPTH)) && (rd_axis != 2'd3));

  assert_halt_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_setup[WMW+1:WMW] == 2'b10 && fill_cnt == CW'(DEPTH) && !pop_strb && !act_entry)
      |=> fill_cnt == CW'(DEPTH));

  assert_ovf_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> fill_cnt == CW'(DEPTH));

  assert_src_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && event_flag && $past(event_flag)) |=> !src_flag);

  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !act_entry |=> (fill_cnt == $past(fill_cnt) ||
                    fill_cnt == CW'($past(fill_cnt) + 1'b1) ||
                    fill_cnt == CW'($past(fill_cnt) - 1'b1)));
endmodule

bind fifo3ax_ctrl fifo3ax_ctrl_chk #(.DEPTH(DEPTH), .WMW(WMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_entry(act_entry), .fifo_setup(fifo_setup),
  .pop_strb(pop_strb), .stat_rd(stat_rd), .rd_axis(rd_axis), .fill_cnt(fill_cnt),
  .ovf_flag(ovf_flag), .event_flag(event_flag), .src_flag(src_flag)
);

// File: tb/fifo3ax_ctrl_bench.sv
`timescale 1ns/1ps
module fifo3ax_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic act_entry = 0, trig_in = 0, smp_valid = 0, pop_strb = 0, stat_rd = 0;
  logic [7:0]  fifo_setup = 8'h00;
  logic [13:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic [13:0] rd_data;
  logic [1:0]  rd_axis;
  logic [5:0]  fill_cnt;
  logic wmrk_flag, ovf_flag, event_flag, src_flag;
  int n_chk = 0, n_bad = 0, next_id = 100;

  always #2 clk = ~clk;

  fifo3ax_ctrl u_fifo3ax_ctrl (
    .clk(clk), .rst_n(rst_n), .act_entry(act_entry), .fifo_setup(fifo_setup),
    .trig_in(trig_in), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_z(smp_z), .pop_strb(pop_strb), .stat_rd(stat_rd), .rd_data(rd_data),
    .rd_axis(rd_axis), .fill_cnt(fill_cnt), .wmrk_flag(wmrk_flag),
    .ovf_flag(ovf_flag), .event_flag(event_flag), .src_flag(src_flag)
  );

  // {valid, pop, setup[7:0], expected count[5:0], expected watermark, expected overflow}
  localparam logic [17:0] VEC [10] = '{
    {1'b1, 1'b0, 8'h43, 6'd1, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h43, 6'd2, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h43, 6'd3, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h43, 6'd3, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h43, 6'd3, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h43, 6'd2, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h43, 6'd3, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 6'd3, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h82, 6'd3, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h82, 6'd2, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    smp_valid = 0; pop_strb = 0; stat_rd = 0; act_entry = 0; trig_in = 0;
  endtask

  task automatic push(input int id);
    smp_valid = 1;
    smp_x = 14'(id); smp_y = 14'(id + 1000); smp_z = 14'(id + 2000);
    tick();
  endtask

  task automatic pop1();
    pop_strb = 1;
    tick();
  endtask

  task automatic clr();
    act_entry = 1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset count", fill_cnt, 0);
    chk("R1 reset ovf", ovf_flag, 0);
    chk("R1 reset src", src_flag, 0);
    chk("R1 reset axis", rd_axis, 0);

    for (int i = 0; i < 10; i++) begin
      fifo_setup = VEC[i][15:8];
      pop_strb   = VEC[i][16];
      if (VEC[i][17]) push(next_id++);
      else tick();
      chk($sformatf("R3 table %0d count", i), fill_cnt, int'(VEC[i][7:2]));
      chk($sformatf("R8 table %0d watermark", i), wmrk_flag, int'(VEC[i][1]));
      chk($sformatf("R7 table %0d overflow", i), ovf_flag, int'(VEC[i][0]));
    end

    // R3: arrival order and axis sequence
    fifo_setup = 8'h40; clr();
    push(7); push(8);
    chk("R3 head x", rd_data, 7);
    chk("R3 axis x", rd_axis, 0);
    pop1(); chk("R3 head y", rd_data, 1007); chk("R3 axis y", rd_axis, 1);
    pop1(); chk("R3 head z", rd_data, 2007); chk("R3 count before z pop", fill_cnt, 2);
    pop1(); chk("R3 count after z pop", fill_cnt, 1); chk("R3 next head", rd_data, 8);
    pop1(); pop1(); pop1();
    chk("R3 drained", fill_cnt, 0);
    pop1();
    chk("R3 empty pop count", fill_cnt, 0);
    chk("R3 empty pop axis", rd_axis, 0);

    // R4, R7, R9, R10: overwrite at full
    clr();
    for (int i = 0; i < 32; i++) push(i);
    chk("R4 full count", fill_cnt, 32);
    chk("R7 no ovf at 32", ovf_flag, 0);
    chk("R9 no event", event_flag, 0);
    push(32);
    chk("R4 count stays", fill_cnt, 32);
    chk("R4 oldest dropped", rd_data, 1);
    chk("R7 ovf set", ovf_flag, 1);
    chk("R9 event", event_flag, 1);
    chk("R10 src lags", src_flag, 0);
    tick();
    chk("R10 src set", src_flag, 1);
    stat_rd = 1; tick();
    chk("R10 src cleared", src_flag, 0);
    pop1(); pop1(); pop1();
    chk("R7 count below full", fill_cnt, 31);
    chk("R7 ovf cleared", ovf_flag, 0);
    chk("R4 head after pop", rd_data, 2);
    push(60);
    clr();
    chk("R1 clear count", fill_cnt, 0);
    chk("R1 clear event", event_flag, 0);

    // R5: halting mode
    fifo_setup = 8'h80; clr();
    for (int i = 0; i < 33; i++) push(i);
    chk("R5 count", fill_cnt, 32);
    chk("R5 head kept", rd_data, 0);
    chk("R7 ovf in halt", ovf_flag, 1);

    // R11: arrival together with sample-removing pop at full
    clr();
    for (int i = 0; i < 32; i++) push(i);
    pop1(); pop1();
    pop_strb = 1; push(40);
    chk("R11 count", fill_cnt, 32);
    chk("R11 no ovf", ovf_flag, 0);
    chk("R11 head", rd_data, 1);
    chk("R11 axis", rd_axis, 0);

    // R6: trigger-armed mode
    fifo_setup = 8'hC0; clr();
    for (int i = 0; i < 33; i++) push(i);
    chk("R6 overwrite before trigger", rd_data, 1);
    trig_in = 1; tick();
    push(33);
    chk("R6 halt after trigger", rd_data, 1);
    chk("R6 count", fill_cnt, 32);
    fifo_setup = 8'h40; tick();
    fifo_setup = 8'hC0;
    push(34);
    chk("R6 rearmed overwrites", rd_data, 2);

    // R8, R2: watermark boundary and disabled mode
    fifo_setup = 8'h45; clr();
    for (int i = 0; i < 4; i++) push(i);
    chk("R8 below mark", wmrk_flag, 0);
    push(4);
    chk("R8 at mark", wmrk_flag, 1);
    fifo_setup = 8'h40; tick();
    chk("R8 zero mark", wmrk_flag, 0);
    fifo_setup = 8'h05;
    push(9);
    chk("R2 disabled ignores", fill_cnt, 5);
    chk("R2 watermark field", wmrk_flag, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule